// File: doc/BRIEF.md
# Prioritized Fault Status Recorder

This block keeps the fault syndrome for the two sides of a processor core: one register pair for load/store faults and one for instruction-fetch faults. Each cycle, each side presents a vector of eight fault flags and the address that caused them. When more than one flag is raised, a fixed priority picks one source. Its 5-bit status code goes into that side's status register, split across bit 10 and bits [3:0]. The side's address register is then reloaded, held, or flagged as unreliable, depending on which source won.

Software reads all four registers directly from the output pins. It can overwrite any of them through one shared write-data bus and four write strobes. A hardware capture beats a software write to the same register in the same cycle. The fault pins are plain per-cycle flags with no handshake: the block takes a report every cycle and never applies back-pressure. A stream that feeds the block must therefore treat it as always ready.

Top module: `fault_status_recorder`

## Requirements
- R1: While `rst_n` is low, both status registers and both address registers are zero and both `*_addr_valid` outputs are low.
- R2: Fault vector bit positions, from highest to lowest priority, are: bit0 alignment, bit1 background, bit2 permission, bit3 precise external abort, bit4 imprecise external abort, bit5 precise parity/ECC, bit6 imprecise parity/ECC, bit7 debug event. When several bits are set, the lowest-numbered set bit is the only one recorded.
- R3: On capture, the status register receives code bit 4 in register bit 10 and code bits 3:0 in register bits [3:0], with every other bit zero. The codes are: debug 00010, alignment 00001, background 00000, imprecise parity/ECC 11000, permission 01101, precise parity/ECC 11001, precise external 01000, imprecise external 10110.
- R4: When the winner is bit 0, 1, 2, 3 or 5, the address register takes the presented address on the next edge and `addr_valid` goes high.
- R5: When the winner is bit 4 or bit 6, hardware does not change the address register and `addr_valid` goes low.
- R6: When the winner is bit 7, hardware changes neither the address register nor `addr_valid`.
- R7: A cycle with no fault bits and no writes changes nothing. A new capture replaces the previous status completely.
- R8: A software status write stores only `sw_wdata` bits 10 and 3:0, with all other bits zero. It is ignored when the same side captures a fault in that cycle.
- R9: A software address write loads `sw_wdata` and sets `addr_valid`. It is ignored only when the same side's capture loads the address (R4). When the capture is an imprecise one (R5), the write lands but `addr_valid` is low.
- R10: The two sides are independent: faults and writes on one side never alter the other side's registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| d_fault | input | 8 | Data-side fault flags (R2 order) |
| d_addr | input | DW | Data-side faulting address |
| i_fault | input | 8 | Instruction-side fault flags |
| i_addr | input | DW | Instruction-side faulting address |
| d_fsr_we | input | 1 | Software write strobe, data status |
| d_far_we | input | 1 | Software write strobe, data address |
| i_fsr_we | input | 1 | Software write strobe, instruction status |
| i_far_we | input | 1 | Software write strobe, instruction address |
| sw_wdata | input | DW | Shared software write data |
| d_fsr | output | DW | Data status register |
| d_far | output | DW | Data address register |
| d_addr_valid | output | 1 | Data address register holds a reliable address |
| i_fsr | output | DW | Instruction status register |
| i_far | output | DW | Instruction address register |
| i_addr_valid | output | 1 | Instruction address register holds a reliable address |

## Verification
The bench drives all 256 fault-flag combinations on the data side, with a scrambled copy on the instruction side. A wrong priority chain would record a lower source when flags overlap, and a misplaced code bit 4 would show up in the wrong status bit. Every source is then paired with simultaneous software writes. A design that let software beat a capture, or that blocked the address write on a debug or imprecise fault, would leave stale values. Idle cycles and back-to-back faults catch registers that drift or merge old status with new, and `addr_valid` is followed across sequences that are precise, then imprecise, then debug.

// File: rtl/fsrec_pkg.sv
package fsrec_pkg;
  localparam int NSRC   = 8;
  localparam int IDX_W  = $clog2(NSRC);
  localparam int CODE_W = 5;
  localparam int CODE_HI_POS = 10;

  typedef enum logic [1:0] {
    POL_LOAD      = 2'd0,
    POL_IMPRECISE = 2'd1,
    POL_KEEP      = 2'd2
  } far_pol_e;

  typedef struct packed {
    logic              hit;
    logic [IDX_W-1:0]  idx;
    logic [CODE_W-1:0] code;
    far_pol_e          pol;
  } fsel_t;

  function automatic logic [CODE_W-1:0] src_code(input logic [IDX_W-1:0] i);
    case (i)
      3'd0:    return 5'b00001;
      3'd1:    return 5'b00000;
      3'd2:    return 5'b01101;
      3'd3:    return 5'b01000;
      3'd4:    return 5'b10110;
      3'd5:    return 5'b11001;
      3'd6:    return 5'b11000;
      default: return 5'b00010;
    endcase
  endfunction

  function automatic far_pol_e src_pol(input logic [IDX_W-1:0] i);
    case (i)
      3'd4, 3'd6: return POL_IMPRECISE;
      3'd7:       return POL_KEEP;
      default:    return POL_LOAD;
    endcase
  endfunction
endpackage

// File: rtl/fault_prio_sel.sv
module fault_prio_sel
  import fsrec_pkg::*;
(
  input  logic [NSRC-1:0] req,
  output fsel_t           sel
);
  logic [NSRC-1:0] grant;

  // lowest index wins: a request is granted only if nothing below it is set
  always_comb begin
    logic found;
    found = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      grant[i] = req[i] & ~found;
      found    = found | req[i];
    end
  end

  always_comb begin
    sel.hit = |req;
    sel.idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (grant[i]) sel.idx = IDX_W'(i);
    end
    sel.code = src_code(sel.idx);
    sel.pol  = src_pol(sel.idx);
  end
endmodule

// File: rtl/fault_side_regs.sv
module fault_side_regs
  import fsrec_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] fault,
  input  logic [DW-1:0]   addr,
  input  logic            fsr_we,
  input  logic            far_we,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   fsr,
  output logic [DW-1:0]   far,
  output logic            addr_valid
);
  localparam logic [DW-1:0] FSR_MASK = (DW'(1) << CODE_HI_POS) | DW'(4'hF);

  fsel_t           sel;
  logic [DW-1:0]   fsr_q, far_q, fsr_pack;
  logic            val_q;
  logic            hw_load, hw_impr;

  fault_prio_sel u_sel (.req(fault), .sel(sel));

  assign hw_load = sel.hit && (sel.pol == POL_LOAD);
  assign hw_impr = sel.hit && (sel.pol == POL_IMPRECISE);

  always_comb begin
    fsr_pack = '0;
    fsr_pack[CODE_HI_POS] = sel.code[CODE_W-1];
    fsr_pack[3:0]         = sel.code[3:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsr_q <= '0;
      far_q <= '0;
      val_q <= 1'b0;
    end else begin
      if (sel.hit)     fsr_q <= fsr_pack;
      else if (fsr_we) fsr_q <= wdata & FSR_MASK;

      if (hw_load)     far_q <= addr;
      else if (far_we) far_q <= wdata;

      if (hw_load)     val_q <= 1'b1;
      else if (hw_impr) val_q <= 1'b0;
      else if (far_we) val_q <= 1'b1;
    end
  end

  assign fsr        = fsr_q;
  assign far        = far_q;
  assign addr_valid = val_q;

  a_r3_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (fsr_q & ~FSR_MASK) == '0);
  a_r4_far_load: assert property (@(posedge clk) disable iff (!rst_n)
    hw_load |=> (far_q == $past(addr)) && val_q);
  a_r5_impr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_impr && !far_we) |=> $stable(far_q) && !val_q);
  a_r6_debug_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (sel.hit && sel.pol == POL_KEEP && !far_we) |=> $stable(far_q) && $stable(val_q));
  a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel.hit && !fsr_we && !far_we) |=> $stable(fsr_q) && $stable(far_q) && $stable(val_q));
  a_r8_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (sel.hit && fsr_we) |=> (fsr_q[3:0] == $past(sel.code[3:0])) &&
                            (fsr_q[CODE_HI_POS] == $past(sel.code[CODE_W-1])));
endmodule

// File: rtl/fault_status_recorder.sv
module fault_status_recorder
  import fsrec_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] d_fault,
  input  logic [DW-1:0]   d_addr,
  input  logic [NSRC-1:0] i_fault,
  input  logic [DW-1:0]   i_addr,
  input  logic            d_fsr_we,
  input  logic            d_far_we,
  input  logic            i_fsr_we,
  input  logic            i_far_we,
  input  logic [DW-1:0]   sw_wdata,
  output logic [DW-1:0]   d_fsr,
  output logic [DW-1:0]   d_far,
  output logic            d_addr_valid,
  output logic [DW-1:0]   i_fsr,
  output logic [DW-1:0]   i_far,
  output logic            i_addr_valid
);
  localparam int NSIDE = 2;

  logic [NSIDE-1:0][NSRC-1:0] flt;
  logic [NSIDE-1:0][DW-1:0]   adr, fsr_o, far_o;
  logic [NSIDE-1:0]           fsr_we, far_we, val_o;

  assign flt    = {i_fault, d_fault};
  assign adr    = {i_addr, d_addr};
  assign fsr_we = {i_fsr_we, d_fsr_we};
  assign far_we = {i_far_we, d_far_we};

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    fault_side_regs #(.DW(DW)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .fault      (flt[s]),
      .addr       (adr[s]),
      .fsr_we     (fsr_we[s]),
      .far_we     (far_we[s]),
      .wdata      (sw_wdata),
      .fsr        (fsr_o[s]),
      .far        (far_o[s]),
      .addr_valid (val_o[s])
    );
  end

  assign d_fsr        = fsr_o[0];
  assign d_far        = far_o[0];
  assign d_addr_valid = val_o[0];
  assign i_fsr        = fsr_o[1];
  assign i_far        = far_o[1];
  assign i_addr_valid = val_o[1];
endmodule

// File: tb/fault_status_recorder_test.sv
`timescale 1ns/1ps
module fault_status_recorder_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  d_fault = '0, i_fault = '0;
  logic [31:0] d_addr = '0, i_addr = '0, sw_wdata = '0;
  logic        d_fsr_we = 0, d_far_we = 0, i_fsr_we = 0, i_far_we = 0;
  logic [31:0] d_fsr, d_far, i_fsr, i_far;
  logic        d_addr_valid, i_addr_valid;

  int total = 0, bad = 0;
  bit done = 0;

  logic [31:0] e_fsr [2];
  logic [31:0] e_far [2];
  logic        e_val [2];

  always #2.5 clk = ~clk;

  fault_status_recorder #(.DW(32)) uut (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-side reference from the requirements
  task automatic model(input int s, input logic [7:0] f, input logic [31:0] a,
                       input logic fw, input logic xw, input logic [31:0] wd);
    int w; logic [4:0] c; int pol;
    w = -1;
    for (int i = 7; i >= 0; i--) if (f[i]) w = i;
    if (w >= 0) begin
      case (w)
        0: c = 5'b00001; 1: c = 5'b00000; 2: c = 5'b01101; 3: c = 5'b01000;
        4: c = 5'b10110; 5: c = 5'b11001; 6: c = 5'b11000; default: c = 5'b00010;
      endcase
      pol = (w == 4 || w == 6) ? 1 : (w == 7) ? 2 : 0;
      e_fsr[s] = {21'd0, c[4], 6'd0, c[3:0]};
      if (pol == 0) begin e_far[s] = a; e_val[s] = 1'b1; end
      else begin
        if (xw) e_far[s] = wd;
        if (pol == 1) e_val[s] = 1'b0;
        else if (xw) e_val[s] = 1'b1;
      end
    end else begin
      if (fw) e_fsr[s] = wd & 32'h0000_040F;
      if (xw) begin e_far[s] = wd; e_val[s] = 1'b1; end
    end
  endtask

  task automatic cyc(input logic [7:0] df, input logic [31:0] da,
                     input logic [7:0] ifl, input logic [31:0] ia,
                     input logic dfw, input logic dxw, input logic ifw, input logic ixw,
                     input logic [31:0] wd, input string tag);
    @(negedge clk);
    d_fault = df; d_addr = da; i_fault = ifl; i_addr = ia;
    d_fsr_we = dfw; d_far_we = dxw; i_fsr_we = ifw; i_far_we = ixw; sw_wdata = wd;
    model(0, df, da, dfw, dxw, wd);
    model(1, ifl, ia, ifw, ixw, wd);
    @(posedge clk); #1;
    chk(d_fsr, e_fsr[0], {tag, " d_fsr"});
    chk(d_far, e_far[0], {tag, " d_far"});
    chk({31'd0, d_addr_valid}, {31'd0, e_val[0]}, {tag, " d_valid"});
    chk(i_fsr, e_fsr[1], {tag, " i_fsr"});
    chk(i_far, e_far[1], {tag, " i_far"});
    chk({31'd0, i_addr_valid}, {31'd0, e_val[1]}, {tag, " i_valid"});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 2; s++) begin e_fsr[s] = '0; e_far[s] = '0; e_val[s] = 1'b0; end
    // R1: hold reset with faults and writes active
    d_fault = 8'hFF; i_fault = 8'hFF; d_far_we = 1; i_fsr_we = 1; sw_wdata = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    #1;
    chk(d_fsr, 0, "R1 d_fsr"); chk(d_far, 0, "R1 d_far");
    chk(i_fsr, 0, "R1 i_fsr"); chk(i_far, 0, "R1 i_far");
    chk({31'd0, d_addr_valid}, 0, "R1 d_valid"); chk({31'd0, i_addr_valid}, 0, "R1 i_valid");
    @(negedge clk);
    d_fault = 0; i_fault = 0; d_far_we = 0; i_fsr_we = 0; rst_n = 1'b1;

    // R2 R3 R4 R5 R6 R10: every flag combination
    for (int v = 0; v < 256; v++)
      cyc(8'(v), 32'h1000_0000 + 32'(v) * 32'h0101_0107,
          8'(v) ^ 8'hA5, 32'h8000_0000 - 32'(v) * 32'h0003_0011,
          0, 0, 0, 0, 32'h0, "R2/R3/R4/R5/R6/R10 sweep");

    // R7: idle cycles
    for (int k = 0; k < 4; k++)
      cyc(0, 32'hDEAD_0000 + 32'(k), 0, 32'hBEEF_0000, 0, 0, 0, 0, 32'h1234_5678, "R7 idle");

    // R8 R9: software writes alone, one side at a time
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 32'hFFFF_FFFF, "R8 d_fsr write");
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 32'hA5A5_F3F0, "R8 i_fsr write");
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 32'h0BAD_F00D, "R9 d_far write");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 32'hC001_D00D, "R9 i_far write");

    // R8 R9: capture against simultaneous writes, each source
    for (int i = 0; i < 8; i++) begin
      cyc(8'(1 << i), 32'h4000_0000 + 32'(i), 0, 0, 1, 1, 0, 0,
          32'h7777_0000 + 32'(i), "R8/R9 d collide");
      cyc(0, 0, 8'(1 << i), 32'h5000_0000 + 32'(i), 0, 0, 1, 1,
          32'h6666_0000 + 32'(i), "R8/R9 i collide");
    end

    // R5 R6 R7: precise, imprecise, debug, then overwrite
    cyc(8'h08, 32'hAAAA_0001, 8'h01, 32'hBBBB_0001, 0, 0, 0, 0, 0, "R4 precise");
    cyc(8'h40, 32'hAAAA_0002, 8'h10, 32'hBBBB_0002, 0, 0, 0, 0, 0, "R5 imprecise");
    cyc(8'h80, 32'hAAAA_0003, 8'h80, 32'hBBBB_0003, 0, 0, 0, 0, 0, "R6 debug");
    cyc(8'h20, 32'hAAAA_0004, 8'h04, 32'hBBBB_0004, 0, 0, 0, 0, 0, "R7 overwrite");
    cyc(8'h80, 32'hAAAA_0005, 8'hC0, 32'hBBBB_0005, 0, 0, 0, 0, 0, "R6 debug after valid");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule